// File: doc/BRIEF.md
# Multicycle Instruction Cycle Controller

This block sequences a small accumulator machine through its instruction cycle one register transfer at a time. It holds the program counter, the instruction register, a memory address register, a memory buffer register, an accumulator, a stack pointer and an interrupt-enable flag. It talks to one single-port synchronous memory through an address, a write word, a read word and separate read and write strobes. Each instruction passes through up to four sub-cycles: fetch, an optional indirect step, execute, and an optional interrupt step. The choice of the next sub-cycle depends on the indirect bit of the fetched word, on the opcode, and on the interrupt request together with the enable flag.

Instruction words are 16 bits wide. Bit 15 marks indirect addressing, bits 14:12 hold the opcode, and bits 11:0 hold an address. Every memory read returns its word one clock after the read strobe. The interrupt step pushes the return address through the buffer and address registers onto a descending stack and then vectors to a fixed handler address. A return opcode pops that address and enables interrupts again. The current sub-cycle is visible on a two-bit phase output.

Top module: `instr_cycle_ctrl`

## Requirements
- R1: Fetch loads the address register from the program counter, then issues a read. In the cycle with the fetch read strobe, memAddr equals pcOut. The word that comes back passes through the buffer register into the instruction register.
- R2: The program counter advances by one in the same cycle as the fetch read strobe, and pcOut shows the new value on the next cycle.
- R3: When bit 15 of the fetched word is 1, the low 12 bits go to the address register and a second read runs. The low 12 bits of that second word become the effective address used by execute.
- R4: Opcode field bits 14:12 select the operation. 0 loads the accumulator from memory at the effective address. 1 stores the accumulator there. 2 adds the memory word to the accumulator, modulo 2^16. 3 jumps to the effective address. 4 returns from an interrupt. 5 sets interrupt enable. 6 and 7 change nothing.
- R5: The interrupt step is entered only when interrupt enable is 1 and irqReq is high at the check that follows execute. A pending request while enable is 0 is ignored.
- R6: The interrupt step first decrements the stack pointer. It then writes the zero-extended program counter to memory at the new stack pointer, loads the program counter with VECTOR_ADDR (default 0x200), and clears interrupt enable.
- R7: Return loads the program counter from the low 12 bits of the word at the stack pointer, increments the stack pointer, and sets interrupt enable.
- R8: Read data is taken from memRdata exactly one cycle after the read strobe. Data on any other cycle is never used.
- R9: After reset, pcOut, accOut and ieOut are 0, both strobes are low, phaseOut is fetch, and the stack pointer is STACK_TOP (default 0xF00). The read and write strobes are never high in the same cycle.
- R10: phaseOut reads 0 during fetch, 1 during indirect, 2 during execute and the interrupt check, and 3 during the interrupt step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| memAddr | output | 12 | Memory address, driven from the address register |
| memWdata | output | 16 | Memory write word, driven from the buffer register |
| memRdata | input | 16 | Memory read word, valid one cycle after memRd |
| memRd | output | 1 | Read strobe |
| memWr | output | 1 | Write strobe |
| irqReq | input | 1 | Level interrupt request |
| pcOut | output | 12 | Program counter |
| accOut | output | 16 | Accumulator |
| ieOut | output | 1 | Interrupt enable flag |
| phaseOut | output | 2 | Current sub-cycle |

## Verification
The hardest situation to reach is a request that stays high while the handler runs, followed by the return that re-enables interrupts. That sequence exercises the ignore path, the return pop and the restored stack pointer in turn. The bench enables interrupts with an instruction, raises irqReq at an instruction boundary, and keeps it high through the first handler instruction. It lowers the request just before the return, then raises it once more. The second save must land at the same stack slot, which shows that the stack pointer came back to its original value.

// File: rtl/icc_pkg.sv
package icc_pkg;

  localparam logic [2:0] OP_LOAD  = 3'd0;
  localparam logic [2:0] OP_STORE = 3'd1;
  localparam logic [2:0] OP_ADD   = 3'd2;
  localparam logic [2:0] OP_JUMP  = 3'd3;
  localparam logic [2:0] OP_RET   = 3'd4;
  localparam logic [2:0] OP_ENI   = 3'd5;

  localparam logic [1:0] PH_FETCH = 2'd0;
  localparam logic [1:0] PH_IND   = 2'd1;
  localparam logic [1:0] PH_EXEC  = 2'd2;
  localparam logic [1:0] PH_INT   = 2'd3;

  // Strobes from control to datapath, one per register transfer
  typedef struct packed {
    logic marFromPc;
    logic marFromMbr;
    logic marFromEa;
    logic marFromSp;
    logic mbrFromMem;
    logic mbrFromAcc;
    logic mbrFromPc;
    logic irFromMbr;
    logic pcInc;
    logic pcFromEa;
    logic pcFromMbr;
    logic pcFromVec;
    logic spDec;
    logic spInc;
    logic accLoad;
    logic accAdd;
    logic ieSet;
    logic ieClr;
    logic memRd;
    logic memWr;
  } ctl_t;

endpackage

// File: rtl/icc_control.sv
module icc_control
  import icc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       irqReq,
  input  logic       ieIn,
  input  logic       mbrIndirect,
  input  logic [2:0] opcode,
  output ctl_t       ctl,
  output logic [1:0] phase
);

  typedef enum logic [3:0] {
    S_F0, S_F1, S_F2, S_F3,
    S_I0, S_I1, S_I2,
    S_E0, S_ERD, S_ECAP, S_EALU, S_EWR, S_CHK,
    S_N0, S_N1, S_N2
  } state_t;

  state_t stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= S_F0;
    else       stateQ <= stateD;
  end

  always_comb begin
    ctl    = '0;
    stateD = stateQ;
    unique case (stateQ)
      S_F0: begin ctl.marFromPc = 1'b1; stateD = S_F1; end
      S_F1: begin ctl.memRd = 1'b1; ctl.pcInc = 1'b1; stateD = S_F2; end
      S_F2: begin ctl.mbrFromMem = 1'b1; stateD = S_F3; end
      S_F3: begin
        ctl.irFromMbr = 1'b1;
        stateD = mbrIndirect ? S_I0 : S_E0;
      end
      S_I0: begin ctl.marFromMbr = 1'b1; stateD = S_I1; end
      S_I1: begin ctl.memRd = 1'b1; stateD = S_I2; end
      S_I2: begin ctl.mbrFromMem = 1'b1; stateD = S_E0; end
      S_E0: begin
        case (opcode)
          OP_LOAD, OP_ADD: begin ctl.marFromEa = 1'b1; stateD = S_ERD; end
          OP_STORE: begin
            ctl.marFromEa  = 1'b1;
            ctl.mbrFromAcc = 1'b1;
            stateD = S_EWR;
          end
          OP_JUMP: begin ctl.pcFromEa = 1'b1; stateD = S_CHK; end
          OP_RET:  begin ctl.marFromSp = 1'b1; stateD = S_ERD; end
          OP_ENI:  begin ctl.ieSet = 1'b1; stateD = S_CHK; end
          default: stateD = S_CHK;
        endcase
      end
      S_ERD:  begin ctl.memRd = 1'b1; stateD = S_ECAP; end
      S_ECAP: begin ctl.mbrFromMem = 1'b1; stateD = S_EALU; end
      S_EALU: begin
        case (opcode)
          OP_LOAD: ctl.accLoad = 1'b1;
          OP_ADD:  ctl.accAdd  = 1'b1;
          OP_RET: begin
            ctl.pcFromMbr = 1'b1;
            ctl.spInc     = 1'b1;
            ctl.ieSet     = 1'b1;
          end
          default: ;
        endcase
        stateD = S_CHK;
      end
      S_EWR: begin ctl.memWr = 1'b1; stateD = S_CHK; end
      S_CHK: stateD = (ieIn && irqReq) ? S_N0 : S_F0;
      S_N0: begin ctl.mbrFromPc = 1'b1; ctl.spDec = 1'b1; stateD = S_N1; end
      S_N1: begin ctl.marFromSp = 1'b1; stateD = S_N2; end
      S_N2: begin
        ctl.memWr     = 1'b1;
        ctl.pcFromVec = 1'b1;
        ctl.ieClr     = 1'b1;
        stateD = S_F0;
      end
      default: stateD = S_F0;
    endcase
  end

  always_comb begin
    unique case (stateQ)
      S_F0, S_F1, S_F2, S_F3: phase = PH_FETCH;
      S_I0, S_I1, S_I2:       phase = PH_IND;
      S_N0, S_N1, S_N2:       phase = PH_INT;
      default:                phase = PH_EXEC;
    endcase
  end

  // R5: interrupt step only follows a check that saw enable and request
  assert_int_gate_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_N0) |-> $past(ieIn && irqReq));

  // R9: the two memory strobes never overlap
  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.memRd && ctl.memWr));

endmodule

// File: rtl/icc_datapath.sv
module icc_datapath
  import icc_pkg::*;
#(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned VECTOR_ADDR = 'h200,
  parameter int unsigned STACK_TOP   = 'hF00
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_t              ctl,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              mbrIndirect,
  output logic [2:0]        opcode,
  output logic [ADDR_W-1:0] pcOut,
  output logic [DATA_W-1:0] accOut,
  output logic              ieOut
);

  localparam int unsigned IND_BIT = DATA_W - 1;
  localparam int unsigned OP_LSB  = DATA_W - 4;
  localparam logic [ADDR_W-1:0] VEC   = ADDR_W'(VECTOR_ADDR);
  localparam logic [ADDR_W-1:0] STACK = ADDR_W'(STACK_TOP);

  logic [ADDR_W-1:0] pcQ, marQ, spQ;
  logic [DATA_W-1:0] mbrQ, irQ, accQ;
  logic              ieQ;
  logic [ADDR_W-1:0] effAddr;

  // Direct: address field of IR; indirect: pointer word now held in MBR
  assign effAddr = irQ[IND_BIT] ? mbrQ[ADDR_W-1:0] : irQ[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ  <= '0;
      marQ <= '0;
      spQ  <= STACK;
      mbrQ <= '0;
      irQ  <= '0;
      accQ <= '0;
      ieQ  <= 1'b0;
    end else begin
      if (ctl.marFromPc)       marQ <= pcQ;
      else if (ctl.marFromMbr) marQ <= mbrQ[ADDR_W-1:0];
      else if (ctl.marFromEa)  marQ <= effAddr;
      else if (ctl.marFromSp)  marQ <= spQ;

      if (ctl.mbrFromMem)      mbrQ <= memRdata;
      else if (ctl.mbrFromAcc) mbrQ <= accQ;
      else if (ctl.mbrFromPc)  mbrQ <= DATA_W'(pcQ);

      if (ctl.irFromMbr) irQ <= mbrQ;

      if (ctl.pcInc)          pcQ <= pcQ + 1'b1;
      else if (ctl.pcFromEa)  pcQ <= effAddr;
      else if (ctl.pcFromMbr) pcQ <= mbrQ[ADDR_W-1:0];
      else if (ctl.pcFromVec) pcQ <= VEC;

      if (ctl.spDec)      spQ <= spQ - 1'b1;
      else if (ctl.spInc) spQ <= spQ + 1'b1;

      if (ctl.accLoad)     accQ <= mbrQ;
      else if (ctl.accAdd) accQ <= accQ + mbrQ;

      if (ctl.ieClr)      ieQ <= 1'b0;
      else if (ctl.ieSet) ieQ <= 1'b1;
    end
  end

  assign memAddr     = marQ;
  assign memWdata    = mbrQ;
  assign mbrIndirect = mbrQ[IND_BIT];
  assign opcode      = irQ[OP_LSB +: 3];
  assign pcOut       = pcQ;
  assign accOut      = accQ;
  assign ieOut       = ieQ;

  // R6: vectoring leaves PC at the handler with interrupts masked
  assert_vector_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pcFromVec |=> (pcQ == VEC && !ieQ));

endmodule

// File: rtl/instr_cycle_ctrl.sv
module instr_cycle_ctrl
  import icc_pkg::*;
#(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned VECTOR_ADDR = 'h200,
  parameter int unsigned STACK_TOP   = 'hF00
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              memRd,
  output logic              memWr,
  input  logic              irqReq,
  output logic [ADDR_W-1:0] pcOut,
  output logic [DATA_W-1:0] accOut,
  output logic              ieOut,
  output logic [1:0]        phaseOut
);

  ctl_t       ctl;
  logic       mbrIndirect;
  logic [2:0] opcode;

  icc_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .irqReq     (irqReq),
    .ieIn       (ieOut),
    .mbrIndirect(mbrIndirect),
    .opcode     (opcode),
    .ctl        (ctl),
    .phase      (phaseOut)
  );

  icc_datapath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .VECTOR_ADDR(VECTOR_ADDR),
    .STACK_TOP  (STACK_TOP)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .memRdata   (memRdata),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .mbrIndirect(mbrIndirect),
    .opcode     (opcode),
    .pcOut      (pcOut),
    .accOut     (accOut),
    .ieOut      (ieOut)
  );

  assign memRd = ctl.memRd;
  assign memWr = ctl.memWr;

  // R1: a read during fetch targets the program counter value
  assert_fetch_addr_R1: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && phaseOut == PH_FETCH) |-> (memAddr == pcOut));

endmodule

// File: tb/sim_instr_cycle_ctrl.sv
module sim_instr_cycle_ctrl;

  logic        clk = 1'b0;
  logic        rstN;
  logic [11:0] memAddr;
  logic [15:0] memWdata;
  logic [15:0] rdataQ;
  logic        memRd, memWr;
  logic        irqReq;
  logic [11:0] pcOut;
  logic [15:0] accOut;
  logic        ieOut;
  logic [1:0]  phaseOut;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  instr_cycle_ctrl u0 (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(rdataQ), .memRd(memRd), .memWr(memWr), .irqReq(irqReq),
    .pcOut(pcOut), .accOut(accOut), .ieOut(ieOut), .phaseOut(phaseOut)
  );

  // Memory model: one-cycle read latency, junk when no read was issued
  logic [15:0] mem [0:4095];
  logic        pokeEn = 1'b0;
  logic [11:0] pokeAddr = '0;
  logic [15:0] pokeData = '0;

  always @(posedge clk) begin
    rdataQ <= memRd ? mem[memAddr] : 16'hDEAD;
    if (pokeEn)     mem[pokeAddr] <= pokeData;
    else if (memWr) mem[memAddr]  <= memWdata;
  end

  task automatic poke(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    pokeEn = 1'b1; pokeAddr = a; pokeData = d;
    @(negedge clk);
    pokeEn = 1'b0;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Waits until phase re-enters fetch; reports which phases were seen
  task automatic waitBoundary(output logic sawInd, output logic sawInt);
    logic [1:0] prev;
    sawInd = 1'b0; sawInt = 1'b0;
    prev = phaseOut;
    forever begin
      @(negedge clk);
      if (phaseOut == 2'd1) sawInd = 1'b1;
      if (phaseOut == 2'd3) sawInt = 1'b1;
      if (phaseOut == 2'd0 && prev != 2'd0) break;
      prev = phaseOut;
    end
  endtask

  // {indirect seen, expected pc, expected acc} after each instruction
  localparam logic [28:0] VEC [0:9] = '{
    {1'b0, 12'h001, 16'h0005},
    {1'b0, 12'h002, 16'h0008},
    {1'b1, 12'h003, 16'h000B},
    {1'b0, 12'h004, 16'h000B},
    {1'b1, 12'h005, 16'h0005},
    {1'b0, 12'h020, 16'h0005},
    {1'b0, 12'h021, 16'h000B},
    {1'b1, 12'h030, 16'h000B},
    {1'b0, 12'h031, 16'h000E},
    {1'b0, 12'h032, 16'h000E}
  };

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %h expected %h", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic sInd, sInt;
    rstN = 1'b0;
    irqReq = 1'b0;
    poke(12'h000, 16'h0100); poke(12'h001, 16'h2101); poke(12'h002, 16'hA102);
    poke(12'h003, 16'h1110); poke(12'h004, 16'h8103); poke(12'h005, 16'h3020);
    poke(12'h020, 16'h0110); poke(12'h021, 16'hB104);
    poke(12'h030, 16'h2101); poke(12'h031, 16'h7000); poke(12'h032, 16'h5000);
    poke(12'h033, 16'h0100); poke(12'h034, 16'h1111); poke(12'h035, 16'h7000);
    poke(12'h100, 16'h0005); poke(12'h101, 16'h0003); poke(12'h102, 16'h0101);
    poke(12'h103, 16'h0100); poke(12'h104, 16'h0030);
    poke(12'h200, 16'h2101); poke(12'h201, 16'h4000);
    @(negedge clk);

    check("R9 reset pc",    32'(pcOut), 0);
    check("R9 reset acc",   32'(accOut), 0);
    check("R9 reset ie",    32'(ieOut), 0);
    check("R9 reset strobes", 32'({memRd, memWr}), 0);
    check("R10 reset phase", 32'(phaseOut), 0);
    rstN = 1'b1;

    do @(negedge clk); while (!memRd);
    check("R1 fetch address", 32'(memAddr), 0);
    check("R2 pc before step", 32'(pcOut), 0);
    @(negedge clk);
    check("R2 pc after step", 32'(pcOut), 1);

    for (int i = 0; i < 10; i++) begin
      waitBoundary(sInd, sInt);
      check("R4 R8 acc", 32'(accOut), 32'(VEC[i][15:0]));
      check("R4 pc", 32'(pcOut), 32'(VEC[i][27:16]));
      check("R3 R10 indirect phase", 32'(sInd), 32'(VEC[i][28]));
    end
    check("R4 store word", 32'(mem[12'h110]), 32'h000B);

    waitBoundary(sInd, sInt);  // enable-interrupts opcode
    check("R4 enable", 32'(ieOut), 1);
    irqReq = 1'b1;

    waitBoundary(sInd, sInt);  // load, then interrupt
    check("R10 interrupt phase", 32'(sInt), 1);
    check("R6 vector pc", 32'(pcOut), 32'h200);
    check("R6 ie cleared", 32'(ieOut), 0);
    check("R6 saved pc", 32'(mem[12'hEFF]), 32'h0034);
    check("R4 acc", 32'(accOut), 32'h0005);

    waitBoundary(sInd, sInt);  // handler add with request held high
    check("R5 masked request", 32'(sInt), 0);
    check("R5 pc", 32'(pcOut), 32'h201);
    check("R4 acc", 32'(accOut), 32'h0008);
    irqReq = 1'b0;

    waitBoundary(sInd, sInt);  // return
    check("R7 return pc", 32'(pcOut), 32'h034);
    check("R7 ie set", 32'(ieOut), 1);

    waitBoundary(sInd, sInt);  // store 0x111
    check("R4 store word", 32'(mem[12'h111]), 32'h0008);
    irqReq = 1'b1;

    waitBoundary(sInd, sInt);  // no-op, then interrupt
    check("R7 stack restored", 32'(mem[12'hEFF]), 32'h0036);
    check("R6 vector pc", 32'(pcOut), 32'h200);
    irqReq = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule